// File: doc/BRIEF.md
# Single-Clock FIFO with SECDED Storage and Fault Injection

This block is a synchronous first-in first-out buffer. Each word is protected by a single-error-correct, double-error-detect code while it sits in storage. The user data word is zero-padded up to a whole number of 64-bit segments. Each segment is stored as a 72-bit codeword: an extended Hamming code with seven position parity bits and one overall parity bit. On the way out, the decoder repairs any single flipped bit in a segment and raises a correctable-error flag. When two bits in a segment have flipped, it returns the stored data unrepaired and raises an uncorrectable-error flag.

Two write-side controls let a test harness damage the word being written, so that the error path can be exercised from the ports. The damage travels with that one entry. It shows up as the matching flag exactly when that entry leaves the buffer, and it has no effect on the entries written before or after it. The fault request that flips more bits wins when both controls are raised together.

The write side follows a valid/ready style with `full` as the inverted ready. A word is taken on a clock edge where `wr_valid` is high and `full` is low. A source facing a high `full` must hold its word and retry, because a rejected word is dropped and nothing is stored. The read side is a plain request: `rd_en` with `empty` low pops one entry. That entry appears on `rd_data`, with `rd_valid` and the two flags, one clock later. The registers holding the read data and the flags have no reset.

Top module: `ecc_fifo`

## Requirements
- R1: A write is accepted on a rising clock edge when `wr_valid`=1 and `full`=0. `full` rises once DEPTH entries are held. A write attempted while `full`=1 stores nothing: the entries later read back are exactly the earlier ones.
- R2: A read is accepted on a rising edge when `rd_en`=1 and `empty`=0. `rd_valid` is high for the one cycle after that edge, and `rd_data` plus the flags are meaningful only then. A read attempted while `empty`=1 leaves `rd_valid` low and `rd_data` unchanged.
- R3: Entries leave in the order they were accepted, including when a read and a write are accepted on the same edge.
- R4: A word written with both fault inputs low reads back unchanged, with `err_single`=0 and `err_double`=0.
- R5: With `inj_single`=1 (and `inj_double`=0) on an accepted write, user data bit 0 of that entry is stored inverted. On read, the original word is returned with `err_single`=1 and `err_double`=0.
- R6: With `inj_double`=1 on an accepted write, user data bits 0 and 1 of that entry are stored inverted. On read, the damaged word (original XOR 3) is returned with `err_double`=1 and `err_single`=0.
- R7: With both fault inputs high on one accepted write, the outcome is that of R6 alone: `err_double`=1 and `err_single`=0.
- R8: The flags belong to a single entry. A clean entry read directly after a damaged one reports both flags low.
- R9: While `rst_n`=0 (asynchronous, active low), the buffer is emptied: `empty`=1, `full`=0 and `rd_valid`=0. Entries held before the reset are discarded.
- R10: `rd_data`, `err_single` and `err_double` are not changed by reset. They keep the values from the last accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of pointers and status |
| wr_valid | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| inj_single | input | 1 | Store this word with one flipped bit |
| inj_double | input | 1 | Store this word with two flipped bits |
| full | output | 1 | Buffer holds DEPTH entries; writes are refused |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Word from the last accepted read |
| rd_valid | output | 1 | High for the cycle after an accepted read |
| empty | output | 1 | Buffer holds no entries; reads are refused |
| err_single | output | 1 | Last read word had a corrected single-bit error |
| err_double | output | 1 | Last read word had an uncorrectable double-bit error |

## Verification
The hardest case to reach is a damaged entry sitting at the output right next to clean ones. A sticky flag or a flag taken from the wrong slot only shows up in that arrangement. The stimulus table therefore fills the whole buffer with a mix of clean, single, double and combined fault requests in an alternating pattern. It then drains the buffer while comparing each word and both flags against values derived from the fault code of that table row. Reset retention is reached by performing a damaged read first, so that the registers hold non-trivial values, and then pulsing reset before observing the outputs.

// File: rtl/ecc_fifo_pkg.sv
package ecc_fifo_pkg;
  localparam int SEG_W  = 64;
  localparam int PAR_W  = 7;
  localparam int CW_W   = SEG_W + PAR_W + 1;
  // codeword positions of user data bits 0 and 1 (first non power-of-two slots)
  localparam int D0_POS = 3;
  localparam int D1_POS = 5;

  function automatic logic is_pow2(input int p);
    return (p != 0) && ((p & (p - 1)) == 0);
  endfunction

  function automatic logic [CW_W-1:0] seg_encode(input logic [SEG_W-1:0] d);
    logic [CW_W-1:0] cw;
    int j;
    cw = '0;
    j  = 0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_pow2(p)) begin
        cw[p] = d[j];
        j++;
      end
    end
    for (int k = 0; k < PAR_W; k++) begin
      logic par;
      par = 1'b0;
      for (int p = 1; p < CW_W; p++)
        if (((p >> k) & 1) == 1 && !is_pow2(p)) par ^= cw[p];
      cw[1 << k] = par;
    end
    cw[0] = ^cw[CW_W-1:1];
    return cw;
  endfunction
endpackage

// File: rtl/ecc_seg_dec.sv
module ecc_seg_dec
  import ecc_fifo_pkg::*;
(
  input  logic [CW_W-1:0]  cw_i,
  output logic [SEG_W-1:0] data_o,
  output logic             sgl_o,
  output logic             dbl_o
);
  logic [PAR_W-1:0] syn;
  logic             odd;
  logic [CW_W-1:0]  fixed;

  always_comb begin
    syn = '0;
    for (int p = 1; p < CW_W; p++)
      if (cw_i[p]) syn ^= PAR_W'(p);
    odd = ^cw_i;
  end

  always_comb begin
    fixed = cw_i;
    sgl_o = 1'b0;
    dbl_o = 1'b0;
    if (odd) begin
      if (int'(syn) < CW_W) begin
        fixed[syn] = ~cw_i[syn];
        sgl_o      = 1'b1;
      end else begin
        dbl_o = 1'b1;
      end
    end else if (syn != '0) begin
      dbl_o = 1'b1;
    end
  end

  always_comb begin
    int j;
    j = 0;
    data_o = '0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_pow2(p)) begin
        data_o[j] = fixed[p];
        j++;
      end
    end
  end
endmodule

// File: rtl/ecc_word_codec.sv
module ecc_word_codec
  import ecc_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int NSEG  = (DATA_W + SEG_W - 1) / SEG_W,
  localparam int STO_W = NSEG * CW_W
) (
  input  logic [DATA_W-1:0] enc_data_i,
  input  logic              inj_single_i,
  input  logic              inj_double_i,
  output logic [STO_W-1:0]  enc_word_o,
  input  logic [STO_W-1:0]  dec_word_i,
  output logic [DATA_W-1:0] dec_data_o,
  output logic              dec_single_o,
  output logic              dec_double_o
);
  logic [NSEG*SEG_W-1:0] pad_in;
  logic [NSEG*SEG_W-1:0] pad_out;
  logic [STO_W-1:0]      clean;
  logic [NSEG-1:0]       sgl_v;
  logic [NSEG-1:0]       dbl_v;

  always_comb begin
    pad_in = '0;
    pad_in[DATA_W-1:0] = enc_data_i;
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign clean[s*CW_W +: CW_W] = seg_encode(pad_in[s*SEG_W +: SEG_W]);
    ecc_seg_dec u_dec (
      .cw_i   (dec_word_i[s*CW_W +: CW_W]),
      .data_o (pad_out[s*SEG_W +: SEG_W]),
      .sgl_o  (sgl_v[s]),
      .dbl_o  (dbl_v[s])
    );
  end

  // fault injection: double request wins over single
  always_comb begin
    enc_word_o = clean;
    if (inj_double_i) begin
      enc_word_o[D0_POS] = ~clean[D0_POS];
      enc_word_o[D1_POS] = ~clean[D1_POS];
    end else if (inj_single_i) begin
      enc_word_o[D0_POS] = ~clean[D0_POS];
    end
  end

  assign dec_data_o   = pad_out[DATA_W-1:0];
  assign dec_double_o = |dbl_v;
  assign dec_single_o = (|sgl_v) && !(|dbl_v);

  logic unused_pad;
  assign unused_pad = ^pad_out;
endmodule

// File: rtl/ecc_fifo_ctrl.sv
module ecc_fifo_ctrl #(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req_i,
  input  logic          rd_req_i,
  output logic          wr_fire_o,
  output logic          rd_fire_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [AW:0] wr_ptr, rd_ptr;

  assign empty_o   = (wr_ptr == rd_ptr);
  assign full_o    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign wr_fire_o = wr_req_i && !full_o;
  assign rd_fire_o = rd_req_i && !empty_o;
  assign wr_addr_o = wr_ptr[AW-1:0];
  assign rd_addr_o = rd_ptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_fire_o) wr_ptr <= wr_ptr + 1'b1;
      if (rd_fire_o) rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/ecc_fifo_mem.sv
module ecc_fifo_mem #(
  parameter int WIDTH = 72,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/ecc_fifo.sv
module ecc_fifo
  import ecc_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              inj_single,
  input  logic              inj_double,
  output logic              full,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              empty,
  output logic              err_single,
  output logic              err_double
);
  localparam int NSEG  = (DATA_W + SEG_W - 1) / SEG_W;
  localparam int STO_W = NSEG * CW_W;
  localparam int AW    = $clog2(DEPTH);

  logic              wr_fire, rd_fire;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [STO_W-1:0]  enc_word, mem_word;
  logic [DATA_W-1:0] dec_data;
  logic              dec_single, dec_double;

  ecc_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req_i  (wr_valid),
    .rd_req_i  (rd_en),
    .wr_fire_o (wr_fire),
    .rd_fire_o (rd_fire),
    .wr_addr_o (wr_addr),
    .rd_addr_o (rd_addr),
    .full_o    (full),
    .empty_o   (empty)
  );

  ecc_word_codec #(.DATA_W(DATA_W)) u_codec (
    .enc_data_i   (wr_data),
    .inj_single_i (inj_single),
    .inj_double_i (inj_double),
    .enc_word_o   (enc_word),
    .dec_word_i   (mem_word),
    .dec_data_o   (dec_data),
    .dec_single_o (dec_single),
    .dec_double_o (dec_double)
  );

  ecc_fifo_mem #(.WIDTH(STO_W), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .we_i    (wr_fire),
    .waddr_i (wr_addr),
    .wdata_i (enc_word),
    .raddr_i (rd_addr),
    .rdata_o (mem_word)
  );

  // output data and flags deliberately carry no reset
  always_ff @(posedge clk) begin
    if (rd_fire) begin
      rd_data    <= dec_data;
      err_single <= dec_single;
      err_double <= dec_double;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_fire;
  end
endmodule

// File: rtl/ecc_fifo_chk.sv
module ecc_fifo_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic rd_en,
  input logic full,
  input logic empty,
  input logic rd_valid,
  input logic err_single,
  input logic err_double
);
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_valid && !rd_en) |=> full);

  p_empty_read_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en) |=> !rd_valid);

  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && rd_en) |=> rd_valid);

  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !(err_single && err_double));

  p_status_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  p_reset_state_r9: assert property (@(posedge clk)
    !rst_n |-> (empty && !full && !rd_valid));
endmodule

bind ecc_fifo ecc_fifo_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .rd_en      (rd_en),
  .full       (full),
  .empty      (empty),
  .rd_valid   (rd_valid),
  .err_single (err_single),
  .err_double (err_double)
);

// File: tb/ecc_fifo_tb_top.sv
module ecc_fifo_tb_top;
  localparam int DW    = 16;
  localparam int DEPTH = 8;
  localparam int NV    = 8;

  // fault code per row: bit0 = single request, bit1 = double request
  localparam logic [DW-1:0] VEC_D [NV] = '{16'hA5A5, 16'h1234, 16'hFFFF, 16'h0000,
                                           16'h8001, 16'h7FFE, 16'h5A5A, 16'hC3C3};
  localparam logic [1:0]    VEC_F [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd1, 2'd2, 2'd0, 2'd3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, inj_single = 1'b0, inj_double = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic full, empty, rd_valid, err_single, err_double;
  logic [DW-1:0] rd_data;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ecc_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .inj_single(inj_single), .inj_double(inj_double), .full(full),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty),
    .err_single(err_single), .err_double(err_double)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] d, input logic [1:0] f);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; inj_single = f[0]; inj_double = f[1];
    @(negedge clk);
    wr_valid = 1'b0; inj_single = 1'b0; inj_double = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_read(input string req, input logic [DW-1:0] d, input logic [1:0] f);
    logic [DW-1:0] ed;
    logic es, edb;
    ed  = f[1] ? (d ^ 16'h0003) : d;
    edb = f[1];
    es  = f[0] && !f[1];
    check({req, " valid"}, 32'(rd_valid), 32'd1);
    check({req, " data"}, 32'(rd_data), 32'(ed));
    check({req, " single"}, 32'(err_single), 32'(es));
    check({req, " double"}, 32'(err_double), 32'(edb));
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    check("R9 empty in reset", 32'(empty), 32'd1);
    check("R9 full in reset", 32'(full), 32'd0);
    check("R9 rd_valid in reset", 32'(rd_valid), 32'd0);
    rst_n = 1'b1;

    // table walk: fill with mixed fault requests (R1,R5,R6,R7)
    for (int i = 0; i < NV; i++) push(VEC_D[i], VEC_F[i]);
    check("R1 full after DEPTH writes", 32'(full), 32'd1);
    push(16'hDEAD, 2'd0);  // refused (R1)
    check("R1 full held", 32'(full), 32'd1);
    // drain, checking order (R3), clean (R4), single (R5), double (R6), both (R7), per-entry (R8)
    for (int i = 0; i < NV; i++) begin
      pop();
      check_read($sformatf("R3 R4 R5 R6 R7 R8 row%0d", i), VEC_D[i], VEC_F[i]);
    end
    check("R1 refused write not stored", 32'(empty), 32'd1);

    // read while empty (R2)
    held = rd_data;
    pop();
    check("R2 empty read no valid", 32'(rd_valid), 32'd0);
    check("R2 empty read data held", 32'(rd_data), 32'(held));

    // clean right after damaged (R8)
    push(16'h0F0F, 2'd2);
    push(16'hF0F0, 2'd0);
    pop(); check_read("R6 damaged", 16'h0F0F, 2'd2);
    pop(); check_read("R8 clean after damaged", 16'hF0F0, 2'd0);

    // simultaneous read and write keeps order (R3)
    push(16'h1111, 2'd0);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 16'h2222; rd_en = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; rd_en = 1'b0;
    check_read("R3 simultaneous pop", 16'h1111, 2'd0);
    check("R3 one entry left", 32'(empty), 32'd0);
    pop(); check_read("R3 second entry", 16'h2222, 2'd0);

    // reset retention (R10) and reset discards entries (R9)
    push(16'h3C3C, 2'd1);
    pop(); check_read("R5 before reset", 16'h3C3C, 2'd1);
    push(16'h4444, 2'd0);
    push(16'h5555, 2'd0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R10 data kept", 32'(rd_data), 32'h3C3C);
    check("R10 single kept", 32'(err_single), 32'd1);
    check("R10 double kept", 32'(err_double), 32'd0);
    check("R9 entries discarded", 32'(empty), 32'd1);
    check("R9 rd_valid low", 32'(rd_valid), 32'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule